// File: doc/BRIEF.md
# Tri-port universal bus exchanger

This block exchanges data among three 18-bit ports, A, B and C. Each port keeps its own incoming data in a storage element that can run in one of three ways: transparent, holding, or loading on a rising edge of that port's capture clock. Each port's output shows the stored value of one of the other two ports, picked by that port's select input. An active-low output enable gates each output.

The bidirectional pins are split into an input vector, an output vector and a drive-enable bit for each port. A driver that turns off sets its drive-enable low and forces its output vector to zero. Each port's capture clock is a plain level input that is sampled on the system clock `clk_i`. A rising edge is seen when the level is sampled high and the previous sample was low. Storage loads on that same `clk_i` edge. The transparent path is combinational, so data put on one port can reach another port's output in the same cycle.

Top module: `ube_exchanger`

## Requirements
- R1: While a port's latch enable is high, that port's stored value equals its own input vector in the same cycle, with no clock edge needed.
- R2: While the latch enable is low and no rising capture-clock edge is detected, the stored value keeps its previous value, whatever the input vector does.
- R3: With the latch enable low, a `clk_i` edge at which the port's capture clock is sampled high, after being sampled low at the previous edge, loads the input vector present at that edge. The new value shows from the next cycle.
- R4: Port A outputs the C stored value when its select is 1 and the B stored value when its select is 0.
- R5: Port B outputs the A stored value when its select is 1 and the C stored value when its select is 0.
- R6: Port C outputs the B stored value when its select is 1 and the A stored value when its select is 0.
- R7: When a port's active-low output enable is 1, its drive-enable is 0 and its output vector is all zeros. When the output enable is 0, its drive-enable is 1.
- R8: When the latch enable falls, the stored value keeps the input that was present at the last `clk_i` edge with the latch enable high. A later detected rising capture-clock edge with the latch enable low replaces it.
- R9: Reset (`rst_ni` low) clears every stored value to zero and treats every capture clock as previously low.
- R10: Each port's latch enable and capture clock act only on that port's own stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the capture clocks |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_d_i | input | 18 | Port A pin data in |
| a_le_i | input | 1 | Port A latch enable (1 = transparent) |
| a_cap_clk_i | input | 1 | Port A capture clock level |
| a_sel_i | input | 1 | Port A source select (1 = C, 0 = B) |
| a_oe_ni | input | 1 | Port A active-low output enable |
| a_d_o | output | 18 | Port A pin data out |
| a_oe_o | output | 1 | Port A drive-enable |
| b_d_i | input | 18 | Port B pin data in |
| b_le_i | input | 1 | Port B latch enable |
| b_cap_clk_i | input | 1 | Port B capture clock level |
| b_sel_i | input | 1 | Port B source select (1 = A, 0 = C) |
| b_oe_ni | input | 1 | Port B active-low output enable |
| b_d_o | output | 18 | Port B pin data out |
| b_oe_o | output | 1 | Port B drive-enable |
| c_d_i | input | 18 | Port C pin data in |
| c_le_i | input | 1 | Port C latch enable |
| c_cap_clk_i | input | 1 | Port C capture clock level |
| c_sel_i | input | 1 | Port C source select (1 = B, 0 = A) |
| c_oe_ni | input | 1 | Port C active-low output enable |
| c_d_o | output | 18 | Port C pin data out |
| c_oe_o | output | 1 | Port C drive-enable |

## Verification
Select, enable and transparent paths are combinational: they are due in the same cycle as the input change. A value loaded by a capture-clock rise, or held after the latch enable falls, shows in the cycle after the `clk_i` edge that stored it. The bench drives every input just after the falling edge of `clk_i` and samples 1 ns later, before the next rising edge. It updates its own storage model right after each rising edge, so each check sees exactly the stored state that the last edge produced. A 4096-step sweep walks every combination of the twelve control bits, with fresh data on each step.

// File: rtl/ube_pkg.sv
package ube_pkg;
  localparam int unsigned NPORT = 3;

  // fixed rotation: select=1 picks the port before this one, select=0 the one after
  function automatic int unsigned src_hi(input int unsigned p);
    return (p + NPORT - 1) % NPORT;
  endfunction

  function automatic int unsigned src_lo(input int unsigned p);
    return (p + 1) % NPORT;
  endfunction
endpackage

// File: rtl/ube_rise_det.sv
module ube_rise_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/ube_store.sv
module ube_store #(
  parameter int unsigned W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic         le_i,
  input  logic         cap_clk_i,
  output logic [W-1:0] st_o
);
  logic         rise;
  logic [W-1:0] q_q;

  ube_rise_det u_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (cap_clk_i),
    .rise_o (rise)
  );

  // transparent mode refreshes the hold copy every edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            q_q <= '0;
    else if (le_i || rise)  q_q <= d_i;
  end

  assign st_o = le_i ? d_i : q_q;
endmodule

// File: rtl/ube_out_sel.sv
module ube_out_sel #(
  parameter int unsigned W = 18
) (
  input  logic         sel_i,
  input  logic         oe_ni,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  output logic [W-1:0] data_o,
  output logic         oe_o
);
  always_comb begin
    oe_o   = ~oe_ni;
    data_o = '0;
    if (!oe_ni) data_o = sel_i ? hi_i : lo_i;
  end
endmodule

// File: rtl/ube_exchanger.sv
module ube_exchanger
  import ube_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_d_i,
  input  logic         a_le_i,
  input  logic         a_cap_clk_i,
  input  logic         a_sel_i,
  input  logic         a_oe_ni,
  output logic [W-1:0] a_d_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b_d_i,
  input  logic         b_le_i,
  input  logic         b_cap_clk_i,
  input  logic         b_sel_i,
  input  logic         b_oe_ni,
  output logic [W-1:0] b_d_o,
  output logic         b_oe_o,
  input  logic [W-1:0] c_d_i,
  input  logic         c_le_i,
  input  logic         c_cap_clk_i,
  input  logic         c_sel_i,
  input  logic         c_oe_ni,
  output logic [W-1:0] c_d_o,
  output logic         c_oe_o
);
  logic [NPORT-1:0][W-1:0] din_w;
  logic [NPORT-1:0][W-1:0] st_w;
  logic [NPORT-1:0][W-1:0] dout_w;
  logic [NPORT-1:0]        le_w;
  logic [NPORT-1:0]        cclk_w;
  logic [NPORT-1:0]        sel_w;
  logic [NPORT-1:0]        oen_w;
  logic [NPORT-1:0]        oe_w;

  assign din_w  = {c_d_i, b_d_i, a_d_i};
  assign le_w   = {c_le_i, b_le_i, a_le_i};
  assign cclk_w = {c_cap_clk_i, b_cap_clk_i, a_cap_clk_i};
  assign sel_w  = {c_sel_i, b_sel_i, a_sel_i};
  assign oen_w  = {c_oe_ni, b_oe_ni, a_oe_ni};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam int unsigned HI = src_hi(p);
    localparam int unsigned LO = src_lo(p);

    ube_store #(.W(W)) u_store (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .d_i       (din_w[p]),
      .le_i      (le_w[p]),
      .cap_clk_i (cclk_w[p]),
      .st_o      (st_w[p])
    );

    ube_out_sel #(.W(W)) u_sel (
      .sel_i  (sel_w[p]),
      .oe_ni  (oen_w[p]),
      .hi_i   (st_w[HI]),
      .lo_i   (st_w[LO]),
      .data_o (dout_w[p]),
      .oe_o   (oe_w[p])
    );
  end

  assign a_d_o  = dout_w[0];
  assign b_d_o  = dout_w[1];
  assign c_d_o  = dout_w[2];
  assign a_oe_o = oe_w[0];
  assign b_oe_o = oe_w[1];
  assign c_oe_o = oe_w[2];
endmodule

// File: rtl/ube_exchanger_chk.sv
module ube_exchanger_chk
  import ube_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [NPORT-1:0]        le_i,
  input logic [NPORT-1:0]        cclk_i,
  input logic [NPORT-1:0]        sel_i,
  input logic [NPORT-1:0]        oen_i,
  input logic [NPORT-1:0]        oe_i,
  input logic [NPORT-1:0][W-1:0] d_i,
  input logic [NPORT-1:0][W-1:0] st_i,
  input logic [NPORT-1:0][W-1:0] q_i
);
  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    localparam int unsigned HI = src_hi(p);
    localparam int unsigned LO = src_lo(p);

    a_r1_transparent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      le_i[p] |-> st_i[p] == d_i[p]);

    a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && !le_i[p] && !(cclk_i[p] && !$past(cclk_i[p])))
      |=> (!le_i[p] |-> st_i[p] == $past(st_i[p])));

    a_r3_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && !le_i[p] && cclk_i[p] && !$past(cclk_i[p]))
      |=> (!le_i[p] |-> st_i[p] == $past(d_i[p])));

    a_r8_le_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      le_i[p] |=> (!le_i[p] |-> st_i[p] == $past(d_i[p])));

    // R4 R5 R6: rotation per port
    a_r4_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !oen_i[p] |-> q_i[p] == (sel_i[p] ? st_i[HI] : st_i[LO]));

    a_r7_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oen_i[p] |-> (!oe_i[p] && q_i[p] == '0));

    a_r7_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !oen_i[p] |-> oe_i[p]);
  end
endmodule

bind ube_exchanger ube_exchanger_chk #(.W(W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .le_i   (le_w),
  .cclk_i (cclk_w),
  .sel_i  (sel_w),
  .oen_i  (oen_w),
  .oe_i   (oe_w),
  .d_i    (din_w),
  .st_i   (st_w),
  .q_i    (dout_w)
);

// File: tb/ube_exchanger_tb.sv
`timescale 1ns/1ps
module ube_exchanger_tb;
  localparam int unsigned W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [2:0][W-1:0] din = '0;
  logic [2:0]        le = '0, pck = '0, sel = '0, oen = '0;
  logic [2:0][W-1:0] dout;
  logic [2:0]        oe;
  logic [W-1:0]      a_q, b_q, c_q;
  logic              a_oe, b_oe, c_oe;

  assign dout = {c_q, b_q, a_q};
  assign oe   = {c_oe, b_oe, a_oe};

  ube_exchanger #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .a_d_i(din[0]), .a_le_i(le[0]), .a_cap_clk_i(pck[0]), .a_sel_i(sel[0]), .a_oe_ni(oen[0]),
    .a_d_o(a_q), .a_oe_o(a_oe),
    .b_d_i(din[1]), .b_le_i(le[1]), .b_cap_clk_i(pck[1]), .b_sel_i(sel[1]), .b_oe_ni(oen[1]),
    .b_d_o(b_q), .b_oe_o(b_oe),
    .c_d_i(din[2]), .c_le_i(le[2]), .c_cap_clk_i(pck[2]), .c_sel_i(sel[2]), .c_oe_ni(oen[2]),
    .c_d_o(c_q), .c_oe_o(c_oe)
  );

  int checks = 0;
  int fails  = 0;
  logic [2:0][W-1:0] q_m = '0;
  logic [2:0]        prev_m = '0;

  task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // sample 1 ns after inputs change at the falling edge
  task automatic check_ports(input string tag);
    logic [2:0][W-1:0] st_m;
    #1;
    for (int p = 0; p < 3; p++) st_m[p] = le[p] ? din[p] : q_m[p];
    for (int p = 0; p < 3; p++) begin
      int unsigned hi = (p + 2) % 3;
      int unsigned lo = (p + 1) % 3;
      logic [W-1:0] exp = oen[p] ? '0 : (sel[p] ? st_m[hi] : st_m[lo]);
      string t = tag;
      if (t == "") t = oen[p] ? "R7" : (p == 0 ? "R4" : (p == 1 ? "R5" : "R6"));
      chk(t, $sformatf("port%0d data", p), dout[p], exp);
      chk("R7", $sformatf("port%0d drive", p), W'(oe[p]), W'(!oen[p]));
    end
  endtask

  task automatic tick();
    @(posedge clk);
    for (int p = 0; p < 3; p++)
      if (le[p] || (pck[p] && !prev_m[p])) q_m[p] = din[p];
    prev_m = pck;
    @(negedge clk);
  endtask

  task automatic step(input string tag);
    check_ports(tag);
    tick();
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    step("R9");

    // R1: A transparent, B and C both view A
    din[0] = 18'h2A5A5; le[0] = 1'b1; sel[1] = 1'b1; sel[2] = 1'b0;
    step("R1");
    din[0] = 18'h01234;
    step("R1");

    // R8: latch enable falls, new input ignored
    le[0] = 1'b0; din[0] = 18'h3C3C3;
    step("R8");
    step("R8");

    // R3: rising capture clock loads, visible next cycle
    pck[0] = 1'b1;
    step("R3");
    step("R3");
    din[0] = 18'h00FF0;
    step("R2");
    pck[0] = 1'b0;
    step("R2");
    din[0] = 18'h15555;
    step("R2");
    pck[0] = 1'b1;
    step("R8");
    step("R8");

    // R10: B capture does not touch A or C
    pck[0] = 1'b0; din[1] = 18'h0BEEF; din[2] = 18'h2FACE; pck[1] = 1'b1;
    sel[0] = 1'b1; sel[2] = 1'b1; oen = 3'b000;
    step("R10");
    step("R10");
    le[2] = 1'b1;
    step("R10");

    // full control sweep
    for (int i = 0; i < 4096; i++) begin
      for (int p = 0; p < 3; p++) begin
        logic [3:0] c = 4'(i >> (4 * p));
        {oen[p], sel[p], pck[p], le[p]} = c;
        din[p] = W'($urandom);
      end
      step("");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule